// File: doc/BRIEF.md
# Chip-Selected Parallel-Load Serializer

A register of `W` stages (16 by default) that updates only on the high-to-low edge of its clock. It either takes a whole word from a parallel bus or shifts by one place, with the serial input entering stage 0 and every stage moving one position toward the top. The serial output always shows the top stage. An active-low chip select blocks both operations and keeps the contents frozen. When chip select is low, the mode input chooses between a parallel load and a shift.

Typical use: load a word in parallel, then clock it out MSB first over `W` shifting edges. The block can also be used as a plain serial delay line. The full stage vector is brought out so the contents can be observed. A synchronous active-low reset clears every stage and exists for bench initialisation. A bound checker flags any release of chip select while the clock is high, because that can cause a false clock.

Top module: `par_load_serializer`

## Requirements
- R1: With `rst_n` low at a falling clock edge, every stage of `state` is 0 after that edge.
- R2: With `rst_n` high and `cs_n` high at a falling edge, `state` keeps its value whatever `mode`, `ser_in` and `par_in` carry.
- R3: With `cs_n` low and `mode` = 1 at a falling edge, `state` becomes `par_in`, with bit n going to stage n.
- R4: With `cs_n` low and `mode` = 0 at a falling edge, stage 0 takes `ser_in` and stage n takes the old stage n-1.
- R5: `ser_out` equals the top stage `state[W-1]` after every edge, including right after a parallel load.
- R6: A bit applied at `ser_in` on a shifting edge reaches `ser_out` after exactly `W` shifting edges in total.
- R7: Nothing changes on the rising clock edge. Inputs changed while the clock is high take effect only at the next falling edge.
- R8: Reset overrides chip select and mode: a low `rst_n` clears the stages even when a load is requested.
- R9: `cs_n` may rise only while `clk` is low. A release done that way causes no update, and the checker flags a release while `clk` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; active on its falling edge |
| rst_n | input | 1 | Synchronous active-low clear |
| cs_n | input | 1 | Active-low chip select; high freezes the register |
| mode | input | 1 | 1 = parallel load, 0 = serial shift |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | W | Parallel word; bit n loads stage n |
| ser_out | output | 1 | Top stage of the register |
| state | output | W | All stages, bit n = stage n |

## Verification
Reset and a parallel load can be requested at the same falling edge. The bench provokes this by holding `rst_n` low with `cs_n` low, `mode` high and an all-ones word on the bus, and it expects an all-zero register. Chip select high and a load request also meet at one edge: `mode` is held high with a changing bus while `cs_n` is high, and the bench requires the contents to stay unchanged. A scoreboard model compares `state` and `ser_out` after every edge. Separate mid-cycle samples confirm that nothing moves on the rising edge.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
// Shared types for the parallel-load serializer.
// Assumes: one operation is chosen per falling clock edge.
package sps_pkg;
    typedef enum logic [1:0] {
        SPS_HOLD  = 2'd0,
        SPS_LOAD  = 2'd1,
        SPS_SHIFT = 2'd2,
        SPS_CLEAR = 2'd3
    } sps_op_e;
endpackage

// File: rtl/sps_op_decode.sv
`timescale 1ns/1ps
// Turns reset, chip select and mode into one operation code.
// Priority: clear, then hold (chip select high), then load or shift.
// Assumes: inputs are stable around the falling clock edge.
module sps_op_decode
    import sps_pkg::*;
(
    input  logic    rst_n,
    input  logic    cs_n,
    input  logic    mode,
    output sps_op_e op
);
    // Pick the operation in priority order.
    always_comb begin
        if (!rst_n)     op = SPS_CLEAR;
        else if (cs_n)  op = SPS_HOLD;
        else if (mode)  op = SPS_LOAD;
        else            op = SPS_SHIFT;
    end
endmodule

// File: rtl/sps_stage.sv
`timescale 1ns/1ps
// One register stage, updated on the falling clock edge.
// Assumes: op is decoded outside; shift_bit comes from the stage below.
module sps_stage
    import sps_pkg::*;
(
    input  logic    clk,
    input  sps_op_e op,
    input  logic    load_bit,
    input  logic    shift_bit,
    output logic    q
);
    // Apply the selected operation at the falling edge.
    always_ff @(negedge clk) begin
        case (op)
            SPS_CLEAR: q <= 1'b0;
            SPS_LOAD:  q <= load_bit;
            SPS_SHIFT: q <= shift_bit;
            default:   q <= q;
        endcase
    end
endmodule

// File: rtl/par_load_serializer.sv
`timescale 1ns/1ps
// Parallel-load / serial-shift register with active-low chip select.
// Stage 0 is the serial entry point and stage W-1 drives ser_out.
// Assumes: cs_n is raised only while clk is low (checked by the bound checker).
module par_load_serializer
    import sps_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         mode,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic         ser_out,
    output logic [W-1:0] state
);
    localparam int TOP = W - 1;

    sps_op_e     op;
    logic [W-1:0] shift_src;

    sps_op_decode u_dec (
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .mode  (mode),
        .op    (op)
    );

    // Build the shift source: serial input below stage 0, neighbour below otherwise.
    always_comb begin
        shift_src = {state[W-2:0], ser_in};
    end

    for (genvar i = 0; i < W; i++) begin : g_stage
        sps_stage u_stage (
            .clk       (clk),
            .op        (op),
            .load_bit  (par_in[i]),
            .shift_bit (shift_src[i]),
            .q         (state[i])
        );
    end

    // Serial output is the top stage.
    assign ser_out = state[TOP];
endmodule

// File: rtl/par_load_serializer_chk.sv
`timescale 1ns/1ps
// Protocol and behaviour checker, bound to every par_load_serializer.
// Assumes: samples at the falling edge, the block's only active edge.
module par_load_serializer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         mode,
    input logic         ser_in,
    input logic [W-1:0] par_in,
    input logic         ser_out,
    input logic [W-1:0] state
);
    assert_clear_R1: assert property (@(negedge clk)
        !rst_n |=> (state == '0));

    assert_hold_R2: assert property (@(negedge clk) disable iff (!rst_n)
        cs_n |=> $stable(state));

    assert_load_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (!cs_n && mode) |=> (state == $past(par_in)));

    assert_shift_R4: assert property (@(negedge clk) disable iff (!rst_n)
        (!cs_n && !mode) |=> (state == {$past(state[W-2:0]), $past(ser_in)}));

    assert_top_after_load_R5: assert property (@(negedge clk) disable iff (!rst_n)
        (!cs_n && mode) |=> (ser_out == $past(par_in[W-1])));

    // R9: chip select may only be released while the clock is low.
    always @(posedge cs_n) begin
        if (rst_n === 1'b1) begin
            assert_cs_release_R9: assert (clk == 1'b0)
                else $error("cs_n released while clk high");
        end
    end
endmodule

bind par_load_serializer par_load_serializer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .mode    (mode),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .ser_out (ser_out),
    .state   (state)
);

// File: tb/test_par_load_serializer.sv
`timescale 1ns/1ps
module test_par_load_serializer;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n, cs_n, mode, ser_in;
    logic [W-1:0] par_in;
    logic         ser_out;
    logic [W-1:0] state;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model;
    item_t sb[$];

    always #10 clk = ~clk;

    par_load_serializer #(.W(W)) i_par_load_serializer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode(mode),
        .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out), .state(state)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: after each falling edge, pop and compare one expected item.
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, state, it.exp);
            check("R5", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, it.exp[W-1]});
        end
    end

    // Driver: apply inputs for one falling edge, push the modelled result.
    task automatic op(input logic r, input logic c, input logic m, input logic s,
                      input logic [W-1:0] p, input string tag, input bit mid = 0);
        logic [W-1:0] prev;
        item_t it;
        rst_n = r; cs_n = c; mode = m; ser_in = s; par_in = p;
        prev = model;
        if (!r)      model = '0;
        else if (c)  model = model;
        else if (m)  model = p;
        else         model = {model[W-2:0], s};
        it.exp = model; it.tag = tag;
        sb.push_back(it);
        if (mid) begin
            @(posedge clk); #1;
            check("R7", state, prev);
        end
        @(negedge clk); #3;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model = '0;
        // R1: reset clears
        op(0, 1, 0, 0, '0, "R1");
        op(0, 1, 1, 1, 16'hFFFF, "R1");
        // R3 with R7 mid-cycle samples
        op(1, 0, 1, 0, 16'hA5C3, "R3", 1);
        op(1, 0, 1, 0, 16'h1234, "R3", 1);
        // R2 / R9: release cs_n with clk low, then hold with a load requested
        op(1, 1, 1, 1, 16'hFFFF, "R9");
        op(1, 1, 1, 0, 16'h0F0F, "R2");
        op(1, 1, 0, 1, 16'hBEEF, "R2");
        // R4: shift the word out with a serial pattern
        for (int i = 0; i < W; i++)
            op(1, 0, 0, i[0] ^ i[2], 16'h0000, "R4", (i == 3));
        // R2 hold in the middle of a shift
        op(1, 0, 1, 0, 16'hC001, "R3");
        op(1, 0, 0, 1, 16'h0000, "R4");
        op(1, 1, 0, 0, 16'h5555, "R2");
        op(1, 0, 0, 0, 16'h0000, "R4");
        // R5 right after a load with the top bit low, then high
        op(1, 0, 1, 0, 16'h7FFF, "R5");
        op(1, 0, 1, 0, 16'h8000, "R5");
        // R8: reset while a load is requested
        op(0, 0, 1, 1, 16'hFFFF, "R8");
        // R6: single 1 reaches ser_out after W shifting edges
        op(1, 0, 0, 1, 16'h0000, "R6");
        for (int i = 1; i < W; i++)
            op(1, 0, 0, 0, 16'h0000, "R6");
        check("R6", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, 1'b1});
        op(1, 0, 0, 0, 16'h0000, "R6");
        check("R6", {{(W-1){1'b0}}, ser_out}, '0);
        op(1, 1, 0, 0, 16'h0000, "R9");
        @(negedge clk); #5;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule